// File: doc/BRIEF.md
# Command Ring Tail and Space Tracker

This block manages the producer side of a command ring in memory. The ring size is a power of two. The consumer reports its last known read offset (the head). The producer proposes new write offsets (tails). The block checks each proposal, wraps it into the ring and commits it to the tail register, or rejects it with a reason code.

From the stored head and tail it reports the free byte count. One 64-byte line is always held back as a guard gap, so the tail never advances into the line the consumer is still reading. A ring size that is not a usable power of two is flagged, and the block then refuses every tail.

Top module: `ring_tail_tracker`

## Requirements
- R1: `cfg_err_o` is high whenever `ring_size_i` is zero, is not a power of two, or is below 64. While it is high, every tail proposal is rejected with code 1.
- R2: A proposal greater than `ring_size_i` is rejected with code 1 (out of range). This is the highest-priority reason.
- R3: A proposal whose three low bits are not all zero is rejected with code 2 (misaligned), unless code 1 applies. A committed tail is always 8-byte aligned.
- R4: A proposal is rejected with code 3 when its wrapped value lies in the same 64-byte line as the stored head (equal bits from bit 6 up) and is numerically below the head. This applies only when codes 1 and 2 do not.
- R5: A proposal equal to `ring_size_i` is accepted and commits tail 0.
- R6: An accepted proposal is committed at the next clock edge. From that edge `tail_o` holds the wrapped offset and `tail_ack_o` is high for one cycle with code 0.
- R7: A rejected proposal leaves `tail_o` unchanged. From the next edge `tail_err_o` is high for one cycle with the reason on `tail_err_code_o`.
- R8: A head update stores `head_ofs_i` masked with size minus one, at the next clock edge.
- R9: `free_o` equals (head - tail - 64) masked with size minus one, computed from the stored pointers. After reset both pointers are 0 and `free_o` is size minus 64.
- R10: `tail_ack_o` and `tail_err_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ring_size_i | input | OFS_W+1 | Ring size in bytes |
| head_vld_i | input | 1 | Head update strobe |
| head_ofs_i | input | OFS_W | Reported head byte offset |
| tail_vld_i | input | 1 | Tail proposal strobe |
| tail_ofs_i | input | OFS_W+1 | Proposed tail byte offset |
| cfg_err_o | output | 1 | Ring size unusable |
| tail_ack_o | output | 1 | Proposal accepted (one-cycle pulse) |
| tail_err_o | output | 1 | Proposal rejected (one-cycle pulse) |
| tail_err_code_o | output | 2 | 0 none, 1 range, 2 alignment, 3 line rule |
| tail_o | output | OFS_W | Committed tail offset |
| free_o | output | OFS_W | Free bytes, guard line excluded |

## Verification
Directed cases cover the boundaries of the checks:
- a tail exactly at the ring size, which tells wrap-to-zero apart from a range error;
- a tail one qword past the size;
- a misaligned tail that is also out of range, which shows the order of the codes;
- tails just below the head inside the head's line, versus in the line before it.

Two illegal ring sizes confirm that the configuration guard blocks every commit. Random streams then mix head updates with aligned and unaligned proposals at the largest ring size. Comparing `free_o` against a reference model after each step separates wrapping bugs from errors in the guard-gap arithmetic.

// File: rtl/ring_pkg.sv
package ring_pkg;
  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_RANGE = 2'd1,
    ERR_ALIGN = 2'd2,
    ERR_LINE  = 2'd3
  } tail_err_e;
endpackage

// File: rtl/ring_cfg_chk.sv
module ring_cfg_chk #(
  parameter int OFS_W      = 12,
  parameter int LINE_BYTES = 64,
  localparam int SIZE_W    = OFS_W + 1
) (
  input  logic [SIZE_W-1:0] size_i,
  output logic [OFS_W-1:0]  mask_o,
  output logic              cfg_err_o
);
  logic [SIZE_W-1:0] m_full;

  always_comb begin
    m_full    = size_i - SIZE_W'(1);
    mask_o    = m_full[OFS_W-1:0];
    cfg_err_o = (size_i == '0) || ((size_i & m_full) != '0) ||
                (size_i < SIZE_W'(LINE_BYTES));
  end
endmodule

// File: rtl/ring_tail_check.sv
module ring_tail_check
  import ring_pkg::*;
#(
  parameter int OFS_W       = 12,
  parameter int LINE_BYTES  = 64,
  parameter int ALIGN_BYTES = 8,
  localparam int SIZE_W     = OFS_W + 1,
  localparam int LINE_LSB   = $clog2(LINE_BYTES),
  localparam int ALIGN_LSB  = $clog2(ALIGN_BYTES)
) (
  input  logic [SIZE_W-1:0] prop_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [OFS_W-1:0]  mask_i,
  input  logic [OFS_W-1:0]  head_i,
  input  logic              cfg_err_i,
  output tail_err_e         code_o,
  output logic [OFS_W-1:0]  wrapped_o
);
  logic same_line, behind;

  always_comb begin
    // prop == size masks to zero: end of ring becomes offset 0
    wrapped_o = prop_i[OFS_W-1:0] & mask_i;
    same_line = wrapped_o[OFS_W-1:LINE_LSB] == head_i[OFS_W-1:LINE_LSB];
    behind    = wrapped_o < head_i;
    if (cfg_err_i || (prop_i > size_i))      code_o = ERR_RANGE;
    else if (prop_i[ALIGN_LSB-1:0] != '0)    code_o = ERR_ALIGN;
    else if (same_line && behind)            code_o = ERR_LINE;
    else                                     code_o = ERR_NONE;
  end
endmodule

// File: rtl/ring_space_calc.sv
module ring_space_calc #(
  parameter int OFS_W      = 12,
  parameter int LINE_BYTES = 64
) (
  input  logic [OFS_W-1:0] head_i,
  input  logic [OFS_W-1:0] tail_i,
  input  logic [OFS_W-1:0] mask_i,
  output logic [OFS_W-1:0] free_o
);
  localparam logic [OFS_W-1:0] LINE_C = OFS_W'(LINE_BYTES);

  always_comb free_o = (head_i - tail_i - LINE_C) & mask_i;
endmodule

// File: rtl/ring_tail_tracker.sv
module ring_tail_tracker
  import ring_pkg::*;
#(
  parameter int OFS_W       = 12,
  parameter int LINE_BYTES  = 64,
  parameter int ALIGN_BYTES = 8,
  localparam int SIZE_W     = OFS_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SIZE_W-1:0] ring_size_i,
  input  logic              head_vld_i,
  input  logic [OFS_W-1:0]  head_ofs_i,
  input  logic              tail_vld_i,
  input  logic [SIZE_W-1:0] tail_ofs_i,
  output logic              cfg_err_o,
  output logic              tail_ack_o,
  output logic              tail_err_o,
  output logic [1:0]        tail_err_code_o,
  output logic [OFS_W-1:0]  tail_o,
  output logic [OFS_W-1:0]  free_o
);
  logic [OFS_W-1:0] mask, head_q, tail_q, wrapped;
  tail_err_e        code, code_q;
  logic             cfg_err, ack_q, err_q;

  ring_cfg_chk #(.OFS_W(OFS_W), .LINE_BYTES(LINE_BYTES)) u_cfg (
    .size_i(ring_size_i), .mask_o(mask), .cfg_err_o(cfg_err)
  );

  ring_tail_check #(.OFS_W(OFS_W), .LINE_BYTES(LINE_BYTES), .ALIGN_BYTES(ALIGN_BYTES)) u_chk (
    .prop_i(tail_ofs_i), .size_i(ring_size_i), .mask_i(mask), .head_i(head_q),
    .cfg_err_i(cfg_err), .code_o(code), .wrapped_o(wrapped)
  );

  ring_space_calc #(.OFS_W(OFS_W), .LINE_BYTES(LINE_BYTES)) u_space (
    .head_i(head_q), .tail_i(tail_q), .mask_i(mask), .free_o(free_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      ack_q  <= 1'b0;
      err_q  <= 1'b0;
      code_q <= ERR_NONE;
    end else begin
      if (head_vld_i) head_q <= head_ofs_i & mask;
      ack_q  <= tail_vld_i && (code == ERR_NONE);
      err_q  <= tail_vld_i && (code != ERR_NONE);
      code_q <= tail_vld_i ? code : ERR_NONE;
      if (tail_vld_i && (code == ERR_NONE)) tail_q <= wrapped;
    end
  end

  assign cfg_err_o       = cfg_err;
  assign tail_ack_o      = ack_q;
  assign tail_err_o      = err_q;
  assign tail_err_code_o = code_q;
  assign tail_o          = tail_q;

  AST_ACK_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tail_ack_o && tail_err_o)); // R10
  AST_REJECT_HOLDS_TAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail_err_o |-> $stable(tail_o)); // R7
  AST_ERR_HAS_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail_err_o |-> tail_err_code_o != 2'd0); // R7
  AST_ACK_NO_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail_ack_o |-> tail_err_code_o == 2'd0); // R6
  AST_TAIL_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail_o[$clog2(ALIGN_BYTES)-1:0] == '0); // R3
  AST_CFG_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tail_vld_i && cfg_err_o) |=> (tail_err_o && tail_err_code_o == 2'd1)); // R1
endmodule

// File: tb/ring_tail_tracker_test.sv
module ring_tail_tracker_test;
  localparam int OFS_W = 12;
  localparam int SIZE_W = OFS_W + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [SIZE_W-1:0] size;
  logic head_vld = 1'b0, tail_vld = 1'b0;
  logic [OFS_W-1:0] head_ofs = '0;
  logic [SIZE_W-1:0] tail_ofs = '0;
  logic cfg_err, ack, err;
  logic [1:0] code;
  logic [OFS_W-1:0] tail, free;

  int n_chk = 0, n_fail = 0;
  int head_m = 0, tail_m = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ring_tail_tracker #(.OFS_W(OFS_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ring_size_i(size), .head_vld_i(head_vld),
    .head_ofs_i(head_ofs), .tail_vld_i(tail_vld), .tail_ofs_i(tail_ofs),
    .cfg_err_o(cfg_err), .tail_ack_o(ack), .tail_err_o(err),
    .tail_err_code_o(code), .tail_o(tail), .free_o(free)
  );

  function automatic int exp_code(int p, int h, int s, bit bad);
    int w = p & (s - 1);
    if (bad || p > s) return 1;
    if (p % 8 != 0) return 2;
    if ((w / 64) == (h / 64) && w < h) return 3;
    return 0;
  endfunction

  function automatic int exp_free(int h, int t, int s);
    return (h - t - 64) & (s - 1);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(int s);
    @(negedge clk);
    rst_n = 1'b0;
    size = SIZE_W'(s);
    head_m = 0; tail_m = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic propose(int p, string req);
    int c;
    bit bad = (size == 0) || ((size & (size - 1)) != 0) || (size < 64);
    c = exp_code(p, head_m, int'(size), bad);
    @(negedge clk);
    tail_ofs = SIZE_W'(p);
    tail_vld = 1'b1;
    @(negedge clk);
    tail_vld = 1'b0;
    if (c == 0) tail_m = p & (int'(size) - 1);
    chk({req, " code"}, int'(code), c);
    chk({req, " ack"}, int'(ack), int'(c == 0));
    chk({req, " err"}, int'(err), int'(c != 0));
    chk({req, " tail"}, int'(tail), tail_m);
    if (!bad) chk({req, " R9 free"}, int'(free), exp_free(head_m, tail_m, int'(size)));
  endtask

  task automatic set_head(int h);
    @(negedge clk);
    head_ofs = OFS_W'(h);
    head_vld = 1'b1;
    @(negedge clk);
    head_vld = 1'b0;
    head_m = h & (int'(size) - 1);
    chk("R8/R9 free after head", int'(free), exp_free(head_m, tail_m, int'(size)));
  endtask

  initial begin
    void'($urandom(32'h5eed));
    size = 13'd1024;
    do_reset(1024);
    @(negedge clk);
    chk("R9 reset tail", int'(tail), 0);
    chk("R9 reset free", int'(free), 1024 - 64);
    chk("R1 cfg ok", int'(cfg_err), 0);
    chk("R10 reset ack", int'(ack), 0);
    propose(1024, "R5 size wraps");
    propose(1032, "R2 just past size");
    propose(1025, "R2 priority over align");
    propose(260, "R3 misaligned");
    propose(512, "R6 accept");
    set_head(12'h210);
    propose(12'h208, "R4 behind in line");
    propose(12'h1f8, "R4 previous line ok");
    propose(12'h218, "R4 ahead in line ok");
    propose(12'h210, "R4 equal head ok");
    set_head(12'hc10);
    chk("R8 masked head", int'(free), exp_free(12'hc10 & 1023, tail_m, 1024));
    do_reset(12'h300);
    @(negedge clk);
    chk("R1 non pow2", int'(cfg_err), 1);
    propose(8, "R1 blocked");
    do_reset(32);
    @(negedge clk);
    chk("R1 too small", int'(cfg_err), 1);
    propose(8, "R1 blocked small");
    do_reset(4096);
    for (int i = 0; i < 1500; i++) begin
      if ($urandom % 3 == 0) set_head(int'($urandom % 4096));
      else begin
        int p = int'($urandom % 4200);
        if ($urandom % 4 != 0) p = p & ~7;
        propose(p, "R6/R7 random");
      end
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (150000) @(posedge clk); chk("watchdog", 0, 1); end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule